// File: doc/BRIEF.md
# Pipelined Modular Adder Tree

This block adds N elements of a prime field and returns their sum reduced modulo a prime p. It is meant to sit behind the multipliers of a vector-matrix product, where it collapses the N products of one matrix row into a single field element. Operands come in as one packed vector, with a valid flag, and must already be reduced (each below p). The block takes a new vector on every clock cycle and has no backpressure. The reduced sum leaves a fixed number of cycles later, with a matching valid flag.

The sum is built by a binary tree of registered modular adders. On each level, operands at positions 2i and 2i+1 feed one adder. When a level holds an odd number of operands, the last one goes through a two-stage delay line so that it reaches the next level together with the pair sums. It is placed after those sums. Every adder has two register stages: the first forms the raw sum, and the second subtracts p when the raw sum is at least p. The total latency is therefore twice the number of tree levels, which is ceil(log2 N). The operand count, the element width and the modulus are parameters. The default sums 12 elements of 255 bits.

Top module: `modadd_tree`

## Requirements
- R1: For every accepted vector, `sum_o` equals the sum of the first N operands modulo P, where operand i occupies bits [i*W +: W] of `ops_i`.
- R2: `out_valid_o` is high exactly LAT = 2*ceil(log2 N) cycles after a cycle in which `in_valid_i` was high, and low in every other cycle after reset.
- R3: Vectors presented on consecutive cycles are all accepted, and each produces exactly one result, in order, with no gaps inserted.
- R4: Each result is strictly below P, including when every operand equals P-1.
- R5: Results are correct for odd operand counts (3, 5, 9), where a leftover operand is delayed into the next level.
- R6: One clock edge with `rst_ni` low clears `out_valid_o`, and vectors still in flight at that point produce no output.
- R7: An all-zero operand vector yields a sum of zero.
- R8: A raw sum exactly equal to P yields zero, so the reduction compare includes equality.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | The operand vector on `ops_i` is valid this cycle |
| ops_i | input | N*W | N reduced operands; operand i at bits [i*W +: W] |
| out_valid_o | output | 1 | `sum_o` carries a result this cycle |
| sum_o | output | W | Sum of the operands modulo P |

## Verification
The bench runs the 12-operand default alongside 3-, 5- and 9-operand instances. The odd-count instances catch a leftover operand that is dropped, or that is delayed by the wrong depth: such a design returns sums that mix operands from neighbouring vectors. Operands all set to P-1 drive the largest raw sums, and a pair summing to exactly P targets the `>=` boundary. A design that reduces only on `>` would return P in that case instead of 0. Vectors sent back to back and vectors separated by idle cycles are scoreboarded with their issue cycle, so a valid pipe of the wrong length, or one that loses or repeats a flag, shows up as a latency mismatch or a missing result. A reset in the middle of a stream checks that results still in flight are dropped.

// File: rtl/modadd_tree_pkg.sv
package modadd_tree_pkg;

    // number of operands present at tree level k (level 0 is the input)
    function automatic int lvl_count(input int n, input int k);
        int c;
        c = n;
        for (int i = 0; i < k; i++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

    // number of adder levels needed to reduce n operands to one
    function automatic int num_levels(input int n);
        int c;
        int l;
        c = n;
        l = 0;
        while (c > 1) begin
            c = (c + 1) / 2;
            l++;
        end
        return l;
    endfunction

    localparam int ADD_STAGES = 2;

endpackage

// File: rtl/modadd_pair.sv
module modadd_pair #(
    parameter int           W = 255,
    parameter logic [W-1:0] P = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);

    typedef struct packed {
        logic [W:0]   raw;
        logic [W-1:0] res;
    } add_st_t;

    add_st_t st_d, st_q;
    logic [W:0] diff;

    always_comb begin
        diff = st_q.raw - {1'b0, P};
        st_d.raw = {1'b0, a_i} + {1'b0, b_i};
        if (st_q.raw >= {1'b0, P}) begin
            st_d.res = diff[W-1:0];
        end else begin
            st_d.res = st_q.raw[W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o = st_q.res;

endmodule

// File: rtl/modadd_delay.sv
module modadd_delay #(
    parameter int W     = 255,
    parameter int DEPTH = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[DEPTH-1];

endmodule

// File: rtl/modadd_tree.sv
module modadd_tree
    import modadd_tree_pkg::*;
#(
    parameter int           N = 12,
    parameter int           W = 255,
    parameter logic [W-1:0] P = 255'h73eda753299d7d483339d80809a1d80553bda402fffe5bfeffffffff00000001
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           in_valid_i,
    input  logic [N*W-1:0] ops_i,
    output logic           out_valid_o,
    output logic [W-1:0]   sum_o
);

    localparam int LEVELS = num_levels(N);
    localparam int LAT    = ADD_STAGES * LEVELS;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : gen_lvl
        localparam int CNT   = lvl_count(N, lv);
        localparam int PAIRS = CNT / 2;
        localparam int NXT   = lvl_count(N, lv + 1);

        logic [W-1:0] cur [CNT];
        logic [W-1:0] nxt [NXT];

        if (lv == 0) begin : gen_src_in
            for (genvar i = 0; i < CNT; i++) begin : gen_slice
                assign cur[i] = ops_i[i*W +: W];
            end
        end else begin : gen_src_prev
            for (genvar i = 0; i < CNT; i++) begin : gen_link
                assign cur[i] = gen_lvl[lv-1].nxt[i];
            end
        end

        for (genvar i = 0; i < PAIRS; i++) begin : gen_pair
            modadd_pair #(.W(W), .P(P)) add_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .a_i    (cur[2*i]),
                .b_i    (cur[2*i+1]),
                .sum_o  (nxt[i])
            );
        end

        if (CNT % 2 == 1) begin : gen_odd
            modadd_delay #(.W(W), .DEPTH(ADD_STAGES)) dly_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .d_i    (cur[CNT-1]),
                .q_o    (nxt[PAIRS])
            );
        end
    end

    assign sum_o = gen_lvl[LEVELS-1].nxt[0];

    logic [0:0] vld_out;

    modadd_delay #(.W(1), .DEPTH(LAT)) vld_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (in_valid_i),
        .q_o    (vld_out)
    );

    assign out_valid_o = vld_out[0];

endmodule

// File: rtl/modadd_tree_chk.sv
module modadd_tree_chk #(
    parameter int           N   = 12,
    parameter int           W   = 255,
    parameter logic [W-1:0] P   = '1,
    parameter int           LAT = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           in_valid_i,
    input logic [N*W-1:0] ops_i,
    input logic           out_valid_o,
    input logic [W-1:0]   sum_o
);

    logic [LAT-1:0] vld_sh_q;
    logic [LAT-1:0] zero_sh_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vld_sh_q  <= '0;
            zero_sh_q <= '0;
        end else begin
            vld_sh_q  <= {vld_sh_q[LAT-2:0], in_valid_i};
            zero_sh_q <= {zero_sh_q[LAT-2:0], in_valid_i && (ops_i == '0)};
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o == vld_sh_q[LAT-1]);

    // R4
    sum_below_p_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (sum_o < P));

    // R6
    reset_clears_chk: assert property (@(posedge clk_i)
        !rst_ni |=> !out_valid_o);

    // R7
    zero_in_zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && zero_sh_q[LAT-1]) |-> (sum_o == '0));

endmodule

bind modadd_tree modadd_tree_chk #(.N(N), .W(W), .P(P), .LAT(LAT)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .ops_i       (ops_i),
    .out_valid_o (out_valid_o),
    .sum_o       (sum_o)
);

// File: tb/modadd_tree_tb.sv
`timescale 1ns/1ps
module modadd_tree_tb_top;

    localparam int           W    = 255;
    localparam int           NMAX = 12;
    localparam logic [W-1:0] P    = 255'h73eda753299d7d483339d80809a1d80553bda402fffe5bfeffffffff00000001;
    localparam int           NS [4] = '{12, 3, 5, 9};

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              in_valid = 1'b0;
    logic [NMAX*W-1:0] ops = '0;
    logic              ov [4];
    logic [W-1:0]      so [4];

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_q [4][$];
    int           t_q   [4][$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    modadd_tree #(.N(12), .W(W), .P(P)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .ops_i(ops[12*W-1:0]),
        .out_valid_o(ov[0]), .sum_o(so[0]));
    modadd_tree #(.N(3), .W(W), .P(P)) dut_n3_i (
        .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .ops_i(ops[3*W-1:0]),
        .out_valid_o(ov[1]), .sum_o(so[1]));
    modadd_tree #(.N(5), .W(W), .P(P)) dut_n5_i (
        .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .ops_i(ops[5*W-1:0]),
        .out_valid_o(ov[2]), .sum_o(so[2]));
    modadd_tree #(.N(9), .W(W), .P(P)) dut_n9_i (
        .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .ops_i(ops[9*W-1:0]),
        .out_valid_o(ov[3]), .sum_o(so[3]));

    function automatic int lat_of(input int n);
        return 2 * $clog2(n);
    endfunction

    function automatic logic [W-1:0] ref_sum(input logic [NMAX*W-1:0] v, input int n);
        logic [W+7:0] acc;
        acc = '0;
        for (int i = 0; i < n; i++) acc += {8'd0, v[i*W +: W]};
        return W'(acc % {8'd0, P});
    endfunction

    function automatic logic [W-1:0] rand_elem();
        logic [255:0] r;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return W'(r % {1'b0, P});
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // scoreboard: R1 value, R2 latency, R5 odd counts
    always @(negedge clk) begin
        if (rst_ni) begin
            for (int d = 0; d < 4; d++) begin
                if (ov[d]) begin
                    if (exp_q[d].size() == 0) begin
                        check(1'b0, "R2 spurious valid", W'(d), '0);
                    end else begin
                        logic [W-1:0] e;
                        int t;
                        e = exp_q[d].pop_front();
                        t = t_q[d].pop_front();
                        check(so[d] == e, (d == 0) ? "R1 sum" : "R5 odd-N sum", so[d], e);
                        check(cyc - t == lat_of(NS[d]), "R2 latency", W'(cyc - t),
                              W'(lat_of(NS[d])));
                    end
                end
            end
        end
    end

    task automatic drive(input logic [NMAX*W-1:0] v, input bit vld);
        @(negedge clk);
        ops = v;
        in_valid = vld;
        if (vld) begin
            for (int d = 0; d < 4; d++) begin
                exp_q[d].push_back(ref_sum(v, NS[d]));
                t_q[d].push_back(cyc);
            end
        end
    endtask

    task automatic drain(input string req);
        drive('0, 1'b0);
        repeat (lat_of(NMAX) + 2) @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            check(exp_q[d].size() == 0, req, W'(exp_q[d].size()), '0);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        for (int d = 0; d < 4; d++) check(ov[d] == 1'b0, "R6 reset state", W'(ov[d]), '0);
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic t_zero();
        drive('0, 1'b1);
        drain("R7 zero vector drained");
    endtask

    task automatic t_random_b2b();
        for (int k = 0; k < 200; k++) begin
            logic [NMAX*W-1:0] v;
            for (int i = 0; i < NMAX; i++) v[i*W +: W] = rand_elem();
            drive(v, 1'b1);
        end
        drain("R3 back-to-back all results delivered");
    endtask

    task automatic t_max();
        logic [NMAX*W-1:0] v;
        for (int i = 0; i < NMAX; i++) v[i*W +: W] = P - 1;
        for (int k = 0; k < 4; k++) drive(v, 1'b1);
        drain("R4 all P-1 drained");
    endtask

    task automatic t_exact_p();
        logic [NMAX*W-1:0] v;
        v = '0;
        v[0 +: W] = W'(1);
        v[W +: W] = P - 1;
        drive(v, 1'b1);
        v = '0;
        v[W +: W] = P - 5;
        v[2*W +: W] = W'(5);
        drive(v, 1'b1);
        drain("R8 exact-P drained");
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 40; k++) begin
            logic [NMAX*W-1:0] v;
            for (int i = 0; i < NMAX; i++) v[i*W +: W] = rand_elem();
            drive(v, (k % 3) != 1);
        end
        drain("R2 gapped stream drained");
    endtask

    task automatic t_mid_reset();
        for (int k = 0; k < 3; k++) begin
            logic [NMAX*W-1:0] v;
            for (int i = 0; i < NMAX; i++) v[i*W +: W] = rand_elem();
            drive(v, 1'b1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_ni = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            check(ov[d] == 1'b0, "R6 mid-stream reset", W'(ov[d]), '0);
            exp_q[d].delete();
            t_q[d].delete();
        end
        rst_ni = 1'b1;
        repeat (lat_of(NMAX) + 2) begin
            @(negedge clk);
            for (int d = 0; d < 4; d++)
                check(ov[d] == 1'b0, "R6 flushed vectors stay silent", W'(ov[d]), '0);
        end
        drive({NMAX{W'(7)}}, 1'b1);
        drain("R6 stream after reset");
    endtask

    initial begin
        t_reset_state();
        t_zero();
        t_random_b2b();
        t_max();
        t_exact_p();
        t_gaps();
        t_mid_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule